// File: doc/BRIEF.md
# Eight-Level Interrupt Arbiter

The block gathers eight interrupt request lines, holds them in a request register and filters them through a mask register. It weighs the survivors against the levels already being serviced and raises a single interrupt output toward the CPU. The CPU answers with two acknowledge strobes. The first strobe commits the winning level to the in-service register. The second strobe places an 8-bit vector on the read bus. The CPU can also skip the acknowledge path and poll the block through a read.

Configuration uses a one-bit register select and an 8-bit write bus. An initialization word sequence sets the trigger style, the vector base and the automatic end-of-service option. Run-time command words then handle end-of-service, priority rotation, the special mask behaviour, status read selection and polling. All bus and acknowledge strobes are synchronous, one clock wide, and sampled on the rising edge.

Top module: `irq_arbiter8`

## Requirements
- R1: A write with reg_sel=0 and wr_data[4]=1 starts initialization. The next reg_sel=1 write is the vector-base word. When the first word has bit1=0, one further reg_sel=1 write is taken and discarded. When the first word has bit0=1, one more reg_sel=1 write is the option word. Only after that do reg_sel=1 writes load the mask.
- R2: The start word clears the mask, in-service and request registers. It makes level 7 lowest, selects the request register for status reads and leaves special mask off. It selects level sensing when bit3=1 and edge sensing when bit3=0. When bit0=0 it also turns automatic end-of-service off.
- R3: On the second acknowledge strobe, rd_data shows the vector: bits 7:3 come from bits 7:3 of the vector-base word, and bits 2:0 give the level.
- R4: The first acknowledge strobe sets the in-service bit of the winning level and clears its request bit. If nothing is eligible, level 7 is reported and no in-service bit changes.
- R5: By default level 0 has the highest priority. A set in-service bit blocks requests of its own and lower priority. Requests of higher priority still raise int_req.
- R6: A reg_sel=1 write after initialization loads the mask. A reg_sel=1 read returns the mask. Masked requests never raise int_req.
- R7: Command 0x20 clears the highest-priority in-service bit. Command 0x60|L clears in-service bit L.
- R8: With option word bit1=1, the served in-service bit is cleared at the second acknowledge strobe. With bit1=0 it stays set.
- R9: Command 0xC0|L makes level L lowest. Command 0xA0 clears the top in-service level and makes it lowest. Command 0x80 turns on rotation at automatic end-of-service, and command 0x00 turns it off.
- R10: Command 0x68 turns special mask on and 0x48 turns it off. While special mask is on, a request is eligible when it is unmasked and its own in-service bit is clear, so masking a serviced level lets lower levels through.
- R11: In edge mode, only a 0-to-1 change on a line sets its request bit, and a line held high does not request again. In level mode the request bit follows the line.
- R12: Command 0x0A selects the request register for reg_sel=0 reads and 0x0B selects the in-service register. After command 0x0C, the next reg_sel=0 read returns {pending, 4'b0, level} and services that level as a first acknowledge would.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | One-cycle register write strobe |
| rd_stb | input | 1 | One-cycle register read strobe |
| reg_sel | input | 1 | Register select bit |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data or vector, zero when idle |
| irq_in | input | 8 | Interrupt request lines, bit k is level k |
| int_req | output | 1 | Interrupt request to the CPU |
| ack_stb | input | 1 | Acknowledge strobe, two per acknowledge |

## Verification
A request line becomes visible on int_req one clock after the edge that samples it, because only the request register lies between them. Every register and command write takes effect at the single edge under its strobe. The vector, poll byte and status bytes are combinational from registered state during the strobe cycle. The bench changes inputs on falling edges and reads outputs 1 ns after the falling edge that follows the relevant rising edge. Each result is therefore checked exactly one register stage after the stimulus that produced it.

// File: rtl/irq_arbiter8.sv
module irq_arbiter8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic       rd_stb,
  input  logic       reg_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [7:0] irq_in,
  output logic       int_req,
  input  logic       ack_stb
);
  localparam int N = 8;
  localparam int LW = $clog2(N);

  typedef enum logic [1:0] {S_RUN, S_BASE, S_SKIP, S_OPT} init_t;
  init_t init_st;

  logic [N-1:0] irr, isr, imr, irq_q, elig;
  logic [7-LW:0] base;
  logic [LW-1:0] low, lvl_q;
  logic lvl_ok, lvl_mode, single, want_opt, aeoi, rot_aeoi, smm, rd_isr, poll_pend, ack_ph;

  function automatic logic [LW:0] pick(input logic [N-1:0] v, input logic [LW-1:0] lo);
    logic [LW:0] r;
    r = '0;
    for (int i = N-1; i >= 0; i--) begin
      logic [LW-1:0] k;
      k = lo + LW'(1) + LW'(i);
      if (v[k]) r = {1'b1, k};
    end
    return r;
  endfunction

  function automatic logic [LW-1:0] rank(input logic [LW-1:0] k, input logic [LW-1:0] lo);
    return k - lo - LW'(1);
  endfunction

  logic [LW:0] top, win;
  assign top = pick(isr, low);

  always_comb begin
    for (int k = 0; k < N; k++) begin
      if (smm) elig[k] = irr[k] & ~imr[k] & ~isr[k];
      else     elig[k] = irr[k] & ~imr[k] &
                         (!top[LW] || (rank(LW'(k), low) < rank(top[LW-1:0], low)));
    end
  end

  assign win = pick(elig, low);
  assign int_req = win[LW];

  logic wr_start, wr_cmd2, wr_cmd3, ack1, ack2, poll_go, take;
  logic [N-1:0] clr_bit;
  logic [2:0] cmd;
  logic [LW-1:0] lsel;

  assign wr_start = wr_stb && !reg_sel && wr_data[4];
  assign wr_cmd2  = wr_stb && !reg_sel && !wr_data[4] && !wr_data[3] && init_st == S_RUN;
  assign wr_cmd3  = wr_stb && !reg_sel && !wr_data[4] &&  wr_data[3] && init_st == S_RUN;
  assign ack1     = ack_stb && !ack_ph;
  assign ack2     = ack_stb && ack_ph;
  assign poll_go  = rd_stb && !reg_sel && poll_pend && !wr_stb && !ack_stb;
  assign take     = (ack1 || poll_go) && win[LW] && !wr_start;
  assign clr_bit  = take ? (N'(1) << win[LW-1:0]) : '0;
  assign cmd      = wr_data[7:5];
  assign lsel     = wr_data[LW-1:0];

  assign rd_data = ack2 ? {base, lvl_q} :
                   !rd_stb ? 8'h00 :
                   reg_sel ? imr :
                   poll_pend ? {win[LW], {(7-LW){1'b0}}, win[LW-1:0]} :
                   rd_isr ? isr : irr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr <= '0;
      irq_q <= '0;
    end else begin
      irq_q <= irq_in;
      if (wr_start) irr <= '0;
      else if (lvl_mode) irr <= irq_in & ~clr_bit;
      else irr <= (irr | (irq_in & ~irq_q)) & ~clr_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr <= '0; imr <= '0; base <= '0; low <= LW'(N-1); lvl_q <= '0; lvl_ok <= 1'b0;
      lvl_mode <= 1'b0; single <= 1'b1; want_opt <= 1'b0; aeoi <= 1'b0; rot_aeoi <= 1'b0;
      smm <= 1'b0; rd_isr <= 1'b0; poll_pend <= 1'b0; ack_ph <= 1'b0; init_st <= S_RUN;
    end else if (wr_start) begin
      imr <= '0; isr <= '0; low <= LW'(N-1);
      lvl_mode <= wr_data[3]; single <= wr_data[1]; want_opt <= wr_data[0];
      if (!wr_data[0]) aeoi <= 1'b0;
      rot_aeoi <= 1'b0; smm <= 1'b0; rd_isr <= 1'b0; poll_pend <= 1'b0; ack_ph <= 1'b0;
      init_st <= S_BASE;
    end else if (ack_stb) begin
      ack_ph <= !ack_ph;
      if (!ack_ph) begin
        lvl_ok <= win[LW];
        lvl_q  <= win[LW] ? win[LW-1:0] : LW'(N-1);
        if (win[LW]) isr[win[LW-1:0]] <= 1'b1;
      end else if (aeoi && lvl_ok) begin
        isr[lvl_q] <= 1'b0;
        if (rot_aeoi) low <= lvl_q;
      end
    end else if (wr_stb && reg_sel) begin
      case (init_st)
        S_RUN:  imr <= wr_data;
        S_BASE: begin
          base <= wr_data[7:LW];
          init_st <= !single ? S_SKIP : (want_opt ? S_OPT : S_RUN);
        end
        S_SKIP: init_st <= want_opt ? S_OPT : S_RUN;
        default: begin
          aeoi <= wr_data[1];
          init_st <= S_RUN;
        end
      endcase
    end else if (wr_cmd2) begin
      case (cmd)
        3'b001: if (top[LW]) isr[top[LW-1:0]] <= 1'b0;
        3'b011: isr[lsel] <= 1'b0;
        3'b101: if (top[LW]) begin
          isr[top[LW-1:0]] <= 1'b0;
          low <= top[LW-1:0];
        end
        3'b111: begin
          isr[lsel] <= 1'b0;
          low <= lsel;
        end
        3'b100: rot_aeoi <= 1'b1;
        3'b000: rot_aeoi <= 1'b0;
        3'b110: low <= lsel;
        default: ;
      endcase
    end else if (wr_cmd3) begin
      if (wr_data[6]) smm <= wr_data[5];
      if (wr_data[1]) rd_isr <= wr_data[0];
      poll_pend <= wr_data[2];
    end else if (poll_go) begin
      poll_pend <= 1'b0;
      if (win[LW]) isr[win[LW-1:0]] <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_arbiter8_chk.sv
module irq_arbiter8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic       reg_sel,
  input logic [7:0] wr_data,
  input logic [7:0] irq_in,
  input logic       ack_stb,
  input logic       int_req,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] imr,
  input logic [2:0] low,
  input logic [2:0] lvl_q,
  input logic       lvl_ok,
  input logic       aeoi,
  input logic       ack_ph,
  input logic       poll_pend
);
  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (irr & ~imr) != 8'h00); // R6
  AST_START_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !reg_sel && wr_data[4]) |=> (imr == 8'h00 && isr == 8'h00 && low == 3'd7)); // R2
  AST_ISR_SET_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr & ~$past(isr)) != 8'h00) |->
      ($past(ack_stb && !ack_ph) || $past(rd_stb && !reg_sel && poll_pend))); // R4
  AST_AUTO_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && ack_ph && aeoi && lvl_ok) |=> !isr[$past(lvl_q)]); // R8
  AST_REQ_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr & ~$past(irr)) != 8'h00) |-> ((irr & ~$past(irr) & ~$past(irq_in)) == 8'h00)); // R11
  AST_ACK_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && !(wr_stb && !reg_sel && wr_data[4])) |=> (ack_ph != $past(ack_ph))); // R3
endmodule

bind irq_arbiter8 irq_arbiter8_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .reg_sel(reg_sel),
  .wr_data(wr_data), .irq_in(irq_in), .ack_stb(ack_stb), .int_req(int_req),
  .irr(irr), .isr(isr), .imr(imr), .low(low), .lvl_q(lvl_q), .lvl_ok(lvl_ok),
  .aeoi(aeoi), .ack_ph(ack_ph), .poll_pend(poll_pend)
);

// File: tb/irq_arbiter8_tb_top.sv
`timescale 1ns/1ps
module irq_arbiter8_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_stb = 1'b0, rd_stb = 1'b0, reg_sel = 1'b0, ack_stb = 1'b0;
  logic [7:0] wr_data = '0, irq_in = '0, rd_data;
  logic int_req;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  irq_arbiter8 dut_i (.clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in),
    .int_req(int_req), .ack_stb(ack_stb));

  always #4 clk = ~clk;

  // {mask, lines, expect int_req, expect level}
  localparam logic [19:0] ROWS [8] = '{
    {8'h00, 8'h01, 1'b1, 3'd0},
    {8'h00, 8'h80, 1'b1, 3'd7},
    {8'h00, 8'h28, 1'b1, 3'd3},
    {8'h01, 8'h03, 1'b1, 3'd1},
    {8'hF0, 8'hF0, 1'b0, 3'd7},
    {8'h0F, 8'hFC, 1'b1, 3'd4},
    {8'h00, 8'hFF, 1'b1, 3'd0},
    {8'hFE, 8'h81, 1'b1, 3'd0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_sel = a; wr_data = d; wr_stb = 1'b1;
    @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_sel = a; rd_stb = 1'b1;
    #1 chk(tag, rd_data, exp);
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic lines(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack(input logic [7:0] exp, input string tag);
    @(negedge clk); ack_stb = 1'b1;
    @(negedge clk); ack_stb = 1'b0;
    @(negedge clk); ack_stb = 1'b1;
    #1 chk(tag, rd_data, exp);
    @(negedge clk); ack_stb = 1'b0;
  endtask

  task automatic init(input logic [7:0] w1, input logic [7:0] w2, input logic [7:0] w4);
    wr(1'b0, w1); wr(1'b1, w2);
    if (!w1[1]) wr(1'b1, 8'h00);
    if (w1[0]) wr(1'b1, w4);
  endtask

  task automatic int_is(input logic e, input string tag);
    #1 chk(tag, {7'b0, int_req}, {7'b0, e});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    int_is(1'b0, "R2 reset int_req");
    rd(1'b1, 8'h00, "R6 reset mask");
    rd(1'b0, 8'h00, "R2 reset request reg");

    foreach (ROWS[i]) begin
      logic [7:0] m, l, served;
      logic e; logic [2:0] v;
      {m, l, e, v} = ROWS[i];
      served = e ? (8'h01 << v) : 8'h00;
      init(8'h12, 8'h40, 8'h00);
      wr(1'b1, m);
      rd(1'b1, m, "R6 mask readback");
      lines(l);
      int_is(e, "R5 R6 int_req from table");
      lines(8'h00);
      ack({5'b01000, v}, "R3 R4 table vector");
      wr(1'b0, 8'h0B); rd(1'b0, served, "R4 table in-service");
      wr(1'b0, 8'h0A); rd(1'b0, l & ~served, "R12 R4 table request reg");
    end

    init(8'h11, 8'h48, 8'h02);
    wr(1'b1, 8'h55); rd(1'b1, 8'h55, "R1 four-word sequence then mask");
    lines(8'h02); lines(8'h00);
    ack(8'h49, "R3 vector base from second word");
    wr(1'b0, 8'h0B); rd(1'b0, 8'h00, "R8 auto end clears in-service");
    init(8'h13, 8'h48, 8'h00);
    wr(1'b1, 8'hAA); rd(1'b1, 8'hAA, "R1 skip third word when single");
    lines(8'h01); lines(8'h00);
    ack(8'h48, "R3 vector level 0");
    wr(1'b0, 8'h0B); rd(1'b0, 8'h01, "R8 in-service kept without auto end");
    init(8'h11, 8'h48, 8'h02);
    init(8'h12, 8'h48, 8'h00);
    lines(8'h04); lines(8'h00);
    ack(8'h4A, "R3 vector level 2");
    wr(1'b0, 8'h0B); rd(1'b0, 8'h04, "R2 start without option word drops auto end");

    init(8'h12, 8'h40, 8'h00);
    lines(8'h08); lines(8'h00);
    ack(8'h43, "R4 serve level 3");
    lines(8'h20); lines(8'h00);
    int_is(1'b0, "R5 lower level blocked");
    lines(8'h02); lines(8'h00);
    int_is(1'b1, "R5 higher level passes");
    ack(8'h41, "R5 nested vector");
    wr(1'b0, 8'h0B); rd(1'b0, 8'h0A, "R5 nested in-service");
    wr(1'b0, 8'h20); rd(1'b0, 8'h08, "R7 non-specific end");
    wr(1'b0, 8'h63); rd(1'b0, 8'h00, "R7 specific end");
    int_is(1'b1, "R7 blocked level released");
    ack(8'h45, "R7 released level served");

    init(8'h12, 8'h40, 8'h00);
    wr(1'b0, 8'hC3);
    lines(8'h24); lines(8'h00);
    ack(8'h45, "R9 set lowest 3 makes 5 win over 2");
    wr(1'b0, 8'hA0);
    wr(1'b0, 8'h0B); rd(1'b0, 8'h00, "R9 rotate end clears");
    ack(8'h42, "R9 pending level after rotate");
    init(8'h13, 8'h40, 8'h02);
    wr(1'b0, 8'h80);
    lines(8'h81); lines(8'h00);
    ack(8'h40, "R9 auto rotate first");
    lines(8'h01); lines(8'h00);
    ack(8'h47, "R9 auto rotate puts 0 lowest");

    init(8'h12, 8'h40, 8'h00);
    lines(8'h04); lines(8'h00);
    ack(8'h42, "R10 serve level 2");
    lines(8'h40); lines(8'h00);
    int_is(1'b0, "R10 lower level blocked before special mask");
    wr(1'b1, 8'h04);
    wr(1'b0, 8'h68);
    int_is(1'b1, "R10 special mask lets lower level in");
    ack(8'h46, "R10 special mask vector");
    wr(1'b0, 8'h48);

    init(8'h12, 8'h40, 8'h00);
    lines(8'h10);
    ack(8'h44, "R11 edge serve");
    wr(1'b0, 8'h20);
    int_is(1'b0, "R11 held line no repeat in edge mode");
    lines(8'h00);
    init(8'h1A, 8'h40, 8'h00);
    lines(8'h10);
    ack(8'h44, "R11 level serve");
    wr(1'b0, 8'h20);
    int_is(1'b1, "R11 held line repeats in level mode");
    lines(8'h00);
    int_is(1'b0, "R11 level request follows line");

    init(8'h12, 8'h40, 8'h00);
    lines(8'h08); lines(8'h00);
    wr(1'b0, 8'h0C); rd(1'b0, 8'h83, "R12 poll byte");
    wr(1'b0, 8'h0B); rd(1'b0, 8'h08, "R12 poll sets in-service");
    wr(1'b0, 8'h0A); rd(1'b0, 8'h00, "R12 poll clears request");
    wr(1'b0, 8'h0C); rd(1'b0, 8'h00, "R12 poll with nothing pending");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule